// File: doc/BRIEF.md
# Prioritized Interrupt Acceptance Unit

This block sits between an interrupt message fabric and a processor core. Each incoming message carries a vector, a delivery mode and a level/edge flag. Ordinary deliveries are queued as bits in a request array indexed by vector, alongside a trigger-mode array. Four special kinds (system-management, non-maskable, init and external) do not use the arrays. Each of them keeps a single pending flag and the vector that came with it.

Every cycle the unit decides whether anything should be presented to the core, and if so which kind and which vector. The unmaskable kinds always win and ignore the core's enable flag. With interrupts enabled, an external interrupt comes next, and after it the highest queued ordinary vector. That vector is offered only when it beats the highest vector already in service and its priority class beats the class of the task-priority input.

The core acknowledges the offered interrupt with a one-cycle strobe. Acknowledging an ordinary interrupt moves it from the request array to the in-service array. A one-cycle end-of-interrupt strobe retires the highest in-service vector. All state updates happen on the clock edge. The outputs are combinational from the stored state and from the enable and task-priority inputs.

Top module: `irq_accept_unit`

## Requirements
- R1: A message with mode 0 (fixed) or mode 1 (lowest priority) sets the request bit of its vector and records its trigger flag (1 = level). From the next cycle the highest set request vector appears on `reqTopVec` and its trigger flag on `reqTopLevel`.
- R2: A fixed or lowest-priority message whose vector already has its request bit set changes nothing, including the recorded trigger flag.
- R3: Modes 2 (SMI), 4 (NMI), 5 (INIT) and 7 (external) each keep one pending flag and the vector of the message that set it. While a kind is pending, further messages of that kind are dropped and its stored vector is kept.
- R4: Messages with the reserved modes 3 and 6 change no state.
- R5: A pending SMI, NMI or INIT is reported on `irqPending` whatever the value of `intEnable`. With `intEnable` low, external and ordinary interrupts are not reported.
- R6: An ordinary interrupt is reported only when `intEnable` is high, `reqTopVec` is greater than `svcTopVec`, and `reqTopVec[7:4]` is greater than `taskPriority[7:4]`.
- R7: Selection order is SMI, then NMI, then INIT, then external, then ordinary. `irqKind` encodes 0 none, 1 SMI, 2 NMI, 3 INIT, 4 external, 5 ordinary, and `irqVector` carries the stored vector or `reqTopVec`.
- R8: `ackValid` acts on the reported interrupt. For SMI, NMI, INIT or external it clears only that kind's pending flag. For an ordinary interrupt it clears the request bit and sets the in-service bit of `reqTopVec`. With nothing reported it has no effect.
- R9: `eoiValid` clears the in-service bit of `svcTopVec`, and the next highest in-service vector takes its place.
- R10: Reset clears both arrays, all pending flags and all stored vectors. An empty array reports vector 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| msgValid | input | 1 | Incoming message strobe |
| msgVector | input | 8 | Message vector |
| msgMode | input | 3 | Message delivery mode |
| msgLevel | input | 1 | Message trigger flag, 1 = level |
| intEnable | input | 1 | Core interrupt-enable flag |
| taskPriority | input | 8 | Current task priority |
| ackValid | input | 1 | Core acknowledge of the reported interrupt |
| eoiValid | input | 1 | End-of-interrupt command |
| irqPending | output | 1 | An interrupt is reported to the core |
| irqKind | output | 3 | Kind of the reported interrupt |
| irqVector | output | 8 | Vector of the reported interrupt |
| reqTopVec | output | 8 | Highest set request vector |
| reqTopLevel | output | 1 | Trigger flag recorded for `reqTopVec` |
| svcTopVec | output | 8 | Highest set in-service vector |

## Verification
The bench builds the unit with its default parameters: an 8-bit vector, a 256-entry array and a 4-bit priority class. This lets the extreme vector 0xFF and the top class be driven against a task priority of 0xF0, where the strict class comparison must refuse delivery. With the same width the bench also covers nesting across classes and a full drain through all five interrupt kinds, one acknowledge at a time.

// File: rtl/irq_acc_pkg.sv
package irq_acc_pkg;

  typedef enum logic [2:0] {
    MODE_FIXED  = 3'd0,
    MODE_LOWEST = 3'd1,
    MODE_SMI    = 3'd2,
    MODE_RSV3   = 3'd3,
    MODE_NMI    = 3'd4,
    MODE_INIT   = 3'd5,
    MODE_RSV6   = 3'd6,
    MODE_EXT    = 3'd7
  } dlvMode_e;

  typedef enum logic [2:0] {
    KIND_NONE = 3'd0,
    KIND_SMI  = 3'd1,
    KIND_NMI  = 3'd2,
    KIND_INIT = 3'd3,
    KIND_EXT  = 3'd4,
    KIND_REG  = 3'd5
  } irqKind_e;

  // Strobes from control to the array datapath
  typedef struct packed {
    logic setReq;
    logic reqLevel;
    logic ackReg;
    logic eoi;
  } dpStrobe_t;

  localparam int unsigned NUM_SLOTS = 4;

endpackage

// File: rtl/irq_acc_prienc.sv
module irq_acc_prienc #(
  parameter int unsigned WIDTH = 256,
  localparam int unsigned IDX_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] vecBits,
  output logic [IDX_W-1:0] topIdx
);

  // Highest set bit wins; an empty vector yields index 0
  always_comb begin
    topIdx = '0;
    for (int i = 0; i < WIDTH; i++) begin
      if (vecBits[i]) topIdx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/irq_acc_datapath.sv
module irq_acc_datapath
  import irq_acc_pkg::*;
#(
  parameter int unsigned VEC_W = 8,
  localparam int unsigned NUM_VEC = 1 << VEC_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [VEC_W-1:0] msgVec,
  output logic [VEC_W-1:0] reqTopVec,
  output logic [VEC_W-1:0] svcTopVec,
  output logic             reqTopLevel
);

  logic [NUM_VEC-1:0] reqArr;
  logic [NUM_VEC-1:0] svcArr;
  logic [NUM_VEC-1:0] trigArr;

  irq_acc_prienc #(.WIDTH(NUM_VEC)) u_reqEnc (
    .vecBits(reqArr),
    .topIdx (reqTopVec)
  );

  irq_acc_prienc #(.WIDTH(NUM_VEC)) u_svcEnc (
    .vecBits(svcArr),
    .topIdx (svcTopVec)
  );

  // Request and trigger arrays; a set request bit locks its trigger flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqArr  <= '0;
      trigArr <= '0;
    end else begin
      if (strobe.setReq && !reqArr[msgVec]) begin
        reqArr[msgVec]  <= 1'b1;
        trigArr[msgVec] <= strobe.reqLevel;
      end
      if (strobe.ackReg) begin
        reqArr[reqTopVec] <= 1'b0;
      end
    end
  end

  // In-service array: acknowledge promotes, end-of-interrupt retires
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      svcArr <= '0;
    end else begin
      if (strobe.eoi) begin
        svcArr[svcTopVec] <= 1'b0;
      end
      if (strobe.ackReg) begin
        svcArr[reqTopVec] <= 1'b1;
      end
    end
  end

  assign reqTopLevel = trigArr[reqTopVec];

endmodule

// File: rtl/irq_acc_ctrl.sv
module irq_acc_ctrl
  import irq_acc_pkg::*;
#(
  parameter int unsigned VEC_W   = 8,
  parameter int unsigned CLASS_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             msgValid,
  input  logic [VEC_W-1:0] msgVec,
  input  logic [2:0]       msgMode,
  input  logic             msgLevel,
  input  logic             intEnable,
  input  logic [VEC_W-1:0] taskPriority,
  input  logic             ackValid,
  input  logic             eoiValid,
  input  logic [VEC_W-1:0] reqTopVec,
  input  logic [VEC_W-1:0] svcTopVec,
  output dpStrobe_t        strobe,
  output logic             irqPending,
  output irqKind_e         irqKind,
  output logic [VEC_W-1:0] irqVector
);

  function automatic dlvMode_e slotMode(input int s);
    case (s)
      0:       slotMode = MODE_SMI;
      1:       slotMode = MODE_NMI;
      2:       slotMode = MODE_INIT;
      default: slotMode = MODE_EXT;
    endcase
  endfunction

  function automatic irqKind_e slotKind(input int s);
    case (s)
      0:       slotKind = KIND_SMI;
      1:       slotKind = KIND_NMI;
      2:       slotKind = KIND_INIT;
      default: slotKind = KIND_EXT;
    endcase
  endfunction

  logic [NUM_SLOTS-1:0] slotPend;
  logic [VEC_W-1:0]     slotVec [NUM_SLOTS];
  logic                 regularOk;

  // One pending flag and stored vector per special kind
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic             pendQ;
    logic [VEC_W-1:0] vecQ;
    logic             hit;
    logic             ackHit;

    assign hit    = msgValid && (msgMode == slotMode(s));
    assign ackHit = ackValid && (irqKind == slotKind(s));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pendQ <= 1'b0;
        vecQ  <= '0;
      end else if (hit && !pendQ) begin
        pendQ <= 1'b1;
        vecQ  <= msgVec;
      end else if (ackHit) begin
        pendQ <= 1'b0;
      end
    end

    assign slotPend[s] = pendQ;
    assign slotVec[s]  = vecQ;
  end

  assign regularOk = (reqTopVec > svcTopVec) &&
                     (reqTopVec[VEC_W-1 -: CLASS_W] > taskPriority[VEC_W-1 -: CLASS_W]);

  // Fixed selection order across kinds
  always_comb begin
    irqKind   = KIND_NONE;
    irqVector = '0;
    if (slotPend[0]) begin
      irqKind   = KIND_SMI;
      irqVector = slotVec[0];
    end else if (slotPend[1]) begin
      irqKind   = KIND_NMI;
      irqVector = slotVec[1];
    end else if (slotPend[2]) begin
      irqKind   = KIND_INIT;
      irqVector = slotVec[2];
    end else if (intEnable && slotPend[3]) begin
      irqKind   = KIND_EXT;
      irqVector = slotVec[3];
    end else if (intEnable && regularOk) begin
      irqKind   = KIND_REG;
      irqVector = reqTopVec;
    end
  end

  assign irqPending = (irqKind != KIND_NONE);

  always_comb begin
    strobe.setReq   = msgValid && ((msgMode == MODE_FIXED) || (msgMode == MODE_LOWEST));
    strobe.reqLevel = msgLevel;
    strobe.ackReg   = ackValid && (irqKind == KIND_REG);
    strobe.eoi      = eoiValid;
  end

endmodule

// File: rtl/irq_accept_unit.sv
module irq_accept_unit
  import irq_acc_pkg::*;
#(
  parameter int unsigned VEC_W   = 8,
  parameter int unsigned CLASS_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             msgValid,
  input  logic [VEC_W-1:0] msgVector,
  input  logic [2:0]       msgMode,
  input  logic             msgLevel,
  input  logic             intEnable,
  input  logic [VEC_W-1:0] taskPriority,
  input  logic             ackValid,
  input  logic             eoiValid,
  output logic             irqPending,
  output logic [2:0]       irqKind,
  output logic [VEC_W-1:0] irqVector,
  output logic [VEC_W-1:0] reqTopVec,
  output logic [VEC_W-1:0] svcTopVec,
  output logic             reqTopLevel
);

  dpStrobe_t strobe;
  irqKind_e  kindSel;

  irq_acc_ctrl #(.VEC_W(VEC_W), .CLASS_W(CLASS_W)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .msgValid    (msgValid),
    .msgVec      (msgVector),
    .msgMode     (msgMode),
    .msgLevel    (msgLevel),
    .intEnable   (intEnable),
    .taskPriority(taskPriority),
    .ackValid    (ackValid),
    .eoiValid    (eoiValid),
    .reqTopVec   (reqTopVec),
    .svcTopVec   (svcTopVec),
    .strobe      (strobe),
    .irqPending  (irqPending),
    .irqKind     (kindSel),
    .irqVector   (irqVector)
  );

  irq_acc_datapath #(.VEC_W(VEC_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .msgVec     (msgVector),
    .reqTopVec  (reqTopVec),
    .svcTopVec  (svcTopVec),
    .reqTopLevel(reqTopLevel)
  );

  assign irqKind = kindSel;

endmodule

// File: rtl/irq_accept_unit_chk.sv
module irq_accept_unit_chk
  import irq_acc_pkg::*;
#(
  parameter int unsigned VEC_W   = 8,
  parameter int unsigned CLASS_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             msgValid,
  input logic [VEC_W-1:0] msgVector,
  input logic [2:0]       msgMode,
  input logic             intEnable,
  input logic [VEC_W-1:0] taskPriority,
  input logic             ackValid,
  input logic             eoiValid,
  input logic             irqPending,
  input logic [2:0]       irqKind,
  input logic [VEC_W-1:0] irqVector,
  input logic [VEC_W-1:0] reqTopVec,
  input logic [VEC_W-1:0] svcTopVec,
  input logic             reqTopLevel
);

  logic isOrdinary;
  logic isReserved;
  assign isOrdinary = msgValid && ((msgMode == MODE_FIXED) || (msgMode == MODE_LOWEST));
  assign isReserved = msgValid && ((msgMode == MODE_RSV3) || (msgMode == MODE_RSV6));

  // R1: a queued vector raises the top request to at least that vector
  p_req_set_r1: assert property (@(posedge clk) disable iff (!rstN)
    isOrdinary && !ackValid |=> reqTopVec >= $past(msgVector));

  // R2: repeating the current top vector keeps its trigger flag
  p_dup_keep_r2: assert property (@(posedge clk) disable iff (!rstN)
    isOrdinary && !ackValid && (msgVector == reqTopVec) && (reqTopVec != '0)
    |=> (reqTopLevel == $past(reqTopLevel)) && (reqTopVec == $past(reqTopVec)));

  // R4: reserved modes leave both arrays alone
  p_reserved_r4: assert property (@(posedge clk) disable iff (!rstN)
    isReserved && !ackValid && !eoiValid |=> $stable(reqTopVec) && $stable(svcTopVec));

  // R5: with interrupts disabled only unmaskable kinds can be reported
  p_masked_r5: assert property (@(posedge clk) disable iff (!rstN)
    irqPending && !intEnable
    |-> (irqKind == KIND_SMI) || (irqKind == KIND_NMI) || (irqKind == KIND_INIT));

  // R6: an ordinary report obeys the priority gate
  p_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
    irqKind == KIND_REG |-> intEnable && (irqVector > svcTopVec) &&
      (irqVector[VEC_W-1 -: CLASS_W] > taskPriority[VEC_W-1 -: CLASS_W]));

  // R7: an ordinary report always carries the top request vector
  p_reg_vec_r7: assert property (@(posedge clk) disable iff (!rstN)
    irqKind == KIND_REG |-> irqVector == reqTopVec);

  // R8: acknowledging an ordinary interrupt puts it in service
  p_ack_reg_r8: assert property (@(posedge clk) disable iff (!rstN)
    ackValid && (irqKind == KIND_REG) && !eoiValid |=> svcTopVec == $past(irqVector));

  // R9: end-of-interrupt lowers the top in-service vector
  p_eoi_r9: assert property (@(posedge clk) disable iff (!rstN)
    eoiValid && !ackValid && (svcTopVec != '0) |=> svcTopVec < $past(svcTopVec));

endmodule

bind irq_accept_unit irq_accept_unit_chk #(.VEC_W(VEC_W), .CLASS_W(CLASS_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .msgValid    (msgValid),
  .msgVector   (msgVector),
  .msgMode     (msgMode),
  .intEnable   (intEnable),
  .taskPriority(taskPriority),
  .ackValid    (ackValid),
  .eoiValid    (eoiValid),
  .irqPending  (irqPending),
  .irqKind     (irqKind),
  .irqVector   (irqVector),
  .reqTopVec   (reqTopVec),
  .svcTopVec   (svcTopVec),
  .reqTopLevel (reqTopLevel)
);

// File: tb/irq_accept_unit_tb.sv
module irq_accept_unit_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       msgValid = 1'b0;
  logic [7:0] msgVector = '0;
  logic [2:0] msgMode = '0;
  logic       msgLevel = 1'b0;
  logic       intEnable = 1'b0;
  logic [7:0] taskPriority = '0;
  logic       ackValid = 1'b0;
  logic       eoiValid = 1'b0;
  logic       irqPending;
  logic [2:0] irqKind;
  logic [7:0] irqVector;
  logic [7:0] reqTopVec;
  logic [7:0] svcTopVec;
  logic       reqTopLevel;

  int  checks = 0;
  int  fails = 0;
  bit  done = 1'b0;

  always #4 clk = ~clk;

  irq_accept_unit u_dut (
    .clk(clk), .rstN(rstN), .msgValid(msgValid), .msgVector(msgVector),
    .msgMode(msgMode), .msgLevel(msgLevel), .intEnable(intEnable),
    .taskPriority(taskPriority), .ackValid(ackValid), .eoiValid(eoiValid),
    .irqPending(irqPending), .irqKind(irqKind), .irqVector(irqVector),
    .reqTopVec(reqTopVec), .svcTopVec(svcTopVec), .reqTopLevel(reqTopLevel)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic sendMsg(input logic [7:0] v, input logic [2:0] m, input logic l);
    @(negedge clk);
    msgValid = 1'b1; msgVector = v; msgMode = m; msgLevel = l;
    @(negedge clk);
    msgValid = 1'b0;
    #1;
  endtask

  task automatic doAck();
    @(negedge clk); ackValid = 1'b1;
    @(negedge clk); ackValid = 1'b0;
    #1;
  endtask

  task automatic doEoi();
    @(negedge clk); eoiValid = 1'b1;
    @(negedge clk); eoiValid = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    chk("R10 pending after reset", irqPending, 0);
    chk("R10 kind after reset", irqKind, 0);
    chk("R10 reqTop after reset", reqTopVec, 0);
    chk("R10 svcTop after reset", svcTopVec, 0);
  endtask

  task automatic t_regular();
    intEnable = 1'b1; taskPriority = 8'h00;
    sendMsg(8'h45, 3'd0, 1'b0);
    chk("R1 reqTop fixed", reqTopVec, 'h45);
    chk("R1 edge flag", reqTopLevel, 0);
    chk("R6 pending ordinary", irqPending, 1);
    chk("R7 kind ordinary", irqKind, 5);
    chk("R7 vector ordinary", irqVector, 'h45);
    sendMsg(8'h80, 3'd1, 1'b1);
    chk("R1 reqTop lowest", reqTopVec, 'h80);
    chk("R1 level flag", reqTopLevel, 1);
    sendMsg(8'h80, 3'd0, 1'b0);
    chk("R2 duplicate keeps level", reqTopLevel, 1);
    chk("R2 duplicate keeps top", reqTopVec, 'h80);
    doAck();
    chk("R8 svcTop after ack", svcTopVec, 'h80);
    chk("R8 reqTop after ack", reqTopVec, 'h45);
    chk("R6 lower than in-service blocked", irqPending, 0);
    doEoi();
    chk("R9 svcTop after eoi", svcTopVec, 0);
    chk("R6 lower vector now offered", irqVector, 'h45);
    doAck();
    chk("R8 second ack svcTop", svcTopVec, 'h45);
    chk("R8 second ack reqTop", reqTopVec, 0);
    doEoi();
    chk("R9 drained", svcTopVec, 0);
  endtask

  task automatic t_priority();
    intEnable = 1'b1;
    taskPriority = 8'h50;
    sendMsg(8'h5F, 3'd0, 1'b0);
    chk("R6 equal class blocked", irqPending, 0);
    taskPriority = 8'h4F;
    #1;
    chk("R6 higher class offered", irqKind, 5);
    doAck();
    doEoi();
    taskPriority = 8'hF0;
    sendMsg(8'hFF, 3'd0, 1'b0);
    chk("R6 top class vs top task priority", irqPending, 0);
    chk("R1 vector FF queued", reqTopVec, 'hFF);
    taskPriority = 8'h00;
    #1;
    chk("R6 top vector offered", irqVector, 'hFF);
    doAck();
    chk("R8 top vector in service", svcTopVec, 'hFF);
    doEoi();
    chk("R9 top vector retired", svcTopVec, 0);
  endtask

  task automatic t_masked();
    intEnable = 1'b0; taskPriority = 8'h00;
    sendMsg(8'h33, 3'd7, 1'b0);
    chk("R5 external masked", irqPending, 0);
    sendMsg(8'h02, 3'd4, 1'b0);
    chk("R5 NMI ignores enable", irqPending, 1);
    chk("R5 NMI kind", irqKind, 2);
    sendMsg(8'h09, 3'd4, 1'b0);
    chk("R3 second NMI dropped", irqVector, 'h02);
    sendMsg(8'h44, 3'd7, 1'b0);
    sendMsg(8'hF0, 3'd3, 1'b1);
    sendMsg(8'hE0, 3'd6, 1'b1);
    chk("R4 reserved leaves requests", reqTopVec, 0);
    chk("R4 reserved leaves selection", irqKind, 2);
  endtask

  task automatic t_order();
    sendMsg(8'h90, 3'd0, 1'b0);
    sendMsg(8'h11, 3'd2, 1'b0);
    sendMsg(8'h22, 3'd5, 1'b0);
    chk("R7 SMI first", irqKind, 1);
    chk("R7 SMI vector", irqVector, 'h11);
    intEnable = 1'b1;
    doAck();
    chk("R8 SMI ack leaves NMI", irqKind, 2);
    chk("R8 NMI vector kept", irqVector, 'h02);
    doAck();
    chk("R7 INIT after NMI", irqKind, 3);
    chk("R7 INIT vector", irqVector, 'h22);
    doAck();
    chk("R7 external after INIT", irqKind, 4);
    chk("R3 external keeps first vector", irqVector, 'h33);
    doAck();
    chk("R7 ordinary last", irqKind, 5);
    chk("R7 ordinary vector", irqVector, 'h90);
    chk("R8 external ack left request", reqTopVec, 'h90);
    doAck();
    chk("R8 all drained", irqPending, 0);
    chk("R8 ordinary in service", svcTopVec, 'h90);
    doEoi();
    doAck();
    chk("R8 ack with nothing reported svc", svcTopVec, 0);
    chk("R8 ack with nothing reported req", reqTopVec, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rstN = 1'b1;
    t_regular();
    t_priority();
    t_masked();
    t_order();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule